// File: doc/BRIEF.md
# Sensor Code to Temperature Converter

This block turns the 10-bit reading of an on-die temperature sensor into a signed temperature in millidegrees Celsius. The conversion is a fixed fourth-order polynomial in the sensor code N, evaluated entirely in integer arithmetic. Each power term starts from its coefficient. The term is then multiplied by N and divided by 1000, and this pair of steps repeats once per degree of the term. The four scaled terms and an unscaled constant are added to form the result.

The caller presents a code and pulses a start strobe. The block latches the code and runs the terms one after another through a single shared multiplier and a sequential divider. When the result is ready it raises a one-cycle done pulse. The result stays on the output until the next conversion finishes. Conversions can run back to back, because a new start is accepted in the same cycle as the done pulse.

Top module: `tsense_poly_conv`

## Requirements
- R1: While reset is asserted, and after its release until the first conversion completes, `done_o` is 0 and `result_o` is 0.
- R2: Code 0 converts to exactly -56197.
- R3: For every code N from 0 to 1023, the result is the constant -56197 plus four power terms. Each term starts from its coefficient: -34627 for degree 4, 110230 for degree 3, -191650 for degree 2 and 306040 for degree 1. The term is then replaced by (term * N) / 1000, truncated toward zero, once per unit of its degree.
- R4: Each accepted start produces exactly one `done_o` pulse, and that pulse is one cycle long.
- R5: A start strobe that arrives while a conversion is running is ignored. No extra done pulse follows, and the result belongs to the code accepted first.
- R6: The code is captured in the cycle the start is accepted. Later changes on `code_i` do not affect that conversion.
- R7: Between done pulses, `result_o` holds its value.
- R8: A start that arrives in the same cycle as `done_o` is accepted and begins a new conversion.
- R9: The number of cycles from the start to done is the same for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, accepted only when idle |
| code_i | input | 10 | Raw sensor code N |
| result_o | output | 32 | Signed temperature in millidegrees Celsius |
| done_o | output | 1 | One-cycle pulse marking a new valid result |

## Verification
The done pulse of one conversion and the start of the next can fall in the same cycle. The bench provokes this by running the whole code sweep back to back, raising the next start in exactly the cycle where done is seen high. This is judged correct if every following result matches the integer model for its own code, if the latency stays equal to the one measured from idle, and if done drops again on the next cycle.

// File: rtl/tsense_pkg.sv
`timescale 1ns/1ps
package tsense_pkg;

  localparam int unsigned ORDER     = 4;
  localparam int unsigned CODE_W    = 10;
  localparam int unsigned PROD_W    = 48;
  localparam int unsigned RES_W     = 32;
  localparam int unsigned MAG_W     = 32;
  localparam int unsigned SCALE     = 1000;
  localparam int unsigned DIV_STEPS = 4;
  localparam int signed   OFFSET_MC = -56197;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MUL,
    ST_DIVGO,
    ST_DIVWAIT,
    ST_ACC,
    ST_DONE
  } seq_state_e;

  // Coefficient of the term processed at position idx; position 0 is the highest power.
  function automatic logic signed [31:0] term_coef(input int unsigned idx);
    logic signed [31:0] c;
    case (idx)
      0:       c = -32'sd34627;
      1:       c = 32'sd110230;
      2:       c = -32'sd191650;
      3:       c = 32'sd306040;
      default: c = 32'sd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tc_rst_sync.sv
`timescale 1ns/1ps
module tc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q, sync_n;

  always_comb sync_n = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_n;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tc_seq_div.sv
`timescale 1ns/1ps
// Unsigned restoring divider by a constant, STEPS quotient bits per cycle.
module tc_seq_div #(
  parameter int unsigned MAG_W   = 32,
  parameter int unsigned DIVISOR = 1000,
  parameter int unsigned STEPS   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             done_o,
  output logic [MAG_W-1:0] quot_o
);
  localparam int unsigned RM_W  = $clog2(DIVISOR);
  localparam int unsigned TR_W  = RM_W + 1;
  localparam int unsigned ITER  = MAG_W / STEPS;
  localparam int unsigned CNT_W = $clog2(ITER + 1);

  logic [MAG_W-1:0] sh_q, sh_n;
  logic [RM_W-1:0]  rem_q, rem_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;
  logic             done_q, done_n;

  logic [MAG_W-1:0] sh_c  [STEPS+1];
  logic [RM_W-1:0]  rem_c [STEPS+1];

  assign sh_c[0]  = sh_q;
  assign rem_c[0] = rem_q;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    logic [TR_W-1:0] trial;
    logic            take;
    assign trial        = {rem_c[s], sh_c[s][MAG_W-1]};
    assign take         = (trial >= TR_W'(DIVISOR));
    assign rem_c[s+1]   = take ? RM_W'(trial - TR_W'(DIVISOR)) : trial[RM_W-1:0];
    assign sh_c[s+1]    = {sh_c[s][MAG_W-2:0], take};
  end

  always_comb begin
    sh_n   = sh_q;
    rem_n  = rem_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (start_i) begin
      sh_n  = mag_i;
      rem_n = '0;
      cnt_n = CNT_W'(ITER);
      run_n = 1'b1;
    end else if (run_q) begin
      sh_n  = sh_c[STEPS];
      rem_n = rem_c[STEPS];
      cnt_n = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      rem_q  <= rem_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign done_o = done_q;
  assign quot_o = sh_q;
endmodule

// File: rtl/tc_sequencer.sv
`timescale 1ns/1ps
module tc_sequencer
  import tsense_pkg::*;
#(
  parameter int unsigned N_TERMS = ORDER
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       div_done_i,
  output logic                       busy_o,
  output logic                       capture_o,
  output logic                       load_coef_o,
  output logic                       mul_en_o,
  output logic                       div_start_o,
  output logic                       quot_load_o,
  output logic                       acc_en_o,
  output logic                       finish_o,
  output logic [$clog2(N_TERMS)-1:0] term_o
);
  localparam int unsigned TW    = $clog2(N_TERMS);
  localparam int unsigned POW_W = $clog2(N_TERMS + 1);

  seq_state_e       state_q, state_n;
  logic [TW-1:0]    term_q, term_n;
  logic [POW_W-1:0] pow_q, pow_n;

  always_comb begin
    state_n     = state_q;
    term_n      = term_q;
    pow_n       = pow_q;
    capture_o   = 1'b0;
    load_coef_o = 1'b0;
    mul_en_o    = 1'b0;
    div_start_o = 1'b0;
    quot_load_o = 1'b0;
    acc_en_o    = 1'b0;
    finish_o    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          capture_o = 1'b1;
          term_n    = '0;
          state_n   = ST_LOAD;
        end
      end
      ST_LOAD: begin
        load_coef_o = 1'b1;
        pow_n       = POW_W'(N_TERMS) - POW_W'(term_q);
        state_n     = ST_MUL;
      end
      ST_MUL: begin
        mul_en_o = 1'b1;
        state_n  = ST_DIVGO;
      end
      ST_DIVGO: begin
        div_start_o = 1'b1;
        state_n     = ST_DIVWAIT;
      end
      ST_DIVWAIT: begin
        if (div_done_i) begin
          quot_load_o = 1'b1;
          pow_n       = pow_q - POW_W'(1);
          state_n     = (pow_q == POW_W'(1)) ? ST_ACC : ST_MUL;
        end
      end
      ST_ACC: begin
        acc_en_o = 1'b1;
        if (term_q == TW'(N_TERMS - 1)) begin
          state_n = ST_DONE;
        end else begin
          term_n  = term_q + TW'(1);
          state_n = ST_LOAD;
        end
      end
      ST_DONE: begin
        finish_o = 1'b1;
        state_n  = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      term_q  <= '0;
      pow_q   <= '0;
    end else begin
      state_q <= state_n;
      term_q  <= term_n;
      pow_q   <= pow_n;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign term_o = term_q;
endmodule

// File: rtl/tsense_poly_conv.sv
`timescale 1ns/1ps
module tsense_poly_conv
  import tsense_pkg::*;
#(
  parameter int unsigned CODE_BITS = CODE_W,
  parameter int unsigned WORK_BITS = PROD_W,
  parameter int unsigned OUT_BITS  = RES_W,
  parameter int unsigned DIV_BITS  = MAG_W,
  parameter int unsigned STEP_BITS = DIV_STEPS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [CODE_BITS-1:0]       code_i,
  output logic signed [OUT_BITS-1:0] result_o,
  output logic                       done_o
);
  localparam int unsigned TW = $clog2(ORDER);

  logic rst_n_sync;
  logic busy, capture, load_coef, mul_en, div_start, quot_load, acc_en, finish, div_done;
  logic [TW-1:0] term;
  logic [DIV_BITS-1:0] quot;

  logic [CODE_BITS-1:0]        code_q, code_n;
  logic signed [WORK_BITS-1:0] tmp_q, tmp_n;
  logic signed [WORK_BITS-1:0] prod_q, prod_n;
  logic signed [WORK_BITS-1:0] acc_q, acc_n;
  logic signed [OUT_BITS-1:0]  res_q, res_n;
  logic                        done_q, done_n;

  logic signed [31:0]          coef_w;
  logic signed [WORK_BITS-1:0] coef_ext, code_ext, quot_ext, quot_s, off_ext;
  logic signed [WORK_BITS-1:0] prod_abs, sum_full;

  tc_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  tc_sequencer #(.N_TERMS(ORDER)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .start_i     (start_i),
    .div_done_i  (div_done),
    .busy_o      (busy),
    .capture_o   (capture),
    .load_coef_o (load_coef),
    .mul_en_o    (mul_en),
    .div_start_o (div_start),
    .quot_load_o (quot_load),
    .acc_en_o    (acc_en),
    .finish_o    (finish),
    .term_o      (term)
  );

  tc_seq_div #(.MAG_W(DIV_BITS), .DIVISOR(SCALE), .STEPS(STEP_BITS)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .start_i (div_start),
    .mag_i   (prod_abs[DIV_BITS-1:0]),
    .done_o  (div_done),
    .quot_o  (quot)
  );

  // Operand shaping
  assign coef_w   = term_coef(int'(term));
  assign coef_ext = {{(WORK_BITS-32){coef_w[31]}}, coef_w};
  assign code_ext = {{(WORK_BITS-CODE_BITS){1'b0}}, code_q};
  assign quot_ext = {{(WORK_BITS-DIV_BITS){1'b0}}, quot};
  // prod_q is held through the division, so its sign restores the quotient sign (truncation toward zero)
  assign quot_s   = prod_q[WORK_BITS-1] ? -quot_ext : quot_ext;
  assign prod_abs = prod_q[WORK_BITS-1] ? -prod_q : prod_q;
  assign off_ext  = WORK_BITS'(OFFSET_MC);
  assign sum_full = acc_q + off_ext;

  always_comb begin
    code_n = capture ? code_i : code_q;

    tmp_n = tmp_q;
    if (load_coef)      tmp_n = coef_ext;
    else if (quot_load) tmp_n = quot_s;

    prod_n = mul_en ? (tmp_q * code_ext) : prod_q;

    acc_n = acc_q;
    if (capture)     acc_n = '0;
    else if (acc_en) acc_n = acc_q + tmp_q;

    res_n  = finish ? sum_full[OUT_BITS-1:0] : res_q;
    done_n = finish;
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      code_q <= '0;
      tmp_q  <= '0;
      prod_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      code_q <= code_n;
      tmp_q  <= tmp_n;
      prod_q <= prod_n;
      acc_q  <= acc_n;
      res_q  <= res_n;
      done_q <= done_n;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/tsense_poly_conv_chk.sv
`timescale 1ns/1ps
module tsense_poly_conv_chk #(
  parameter int unsigned WORK_BITS = 48,
  parameter int unsigned OUT_BITS  = 32,
  parameter int unsigned DIV_BITS  = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 done_i,
  input logic                 busy_i,
  input logic [WORK_BITS-1:0] prod_abs_i,
  input logic [WORK_BITS-1:0] sum_full_i,
  input logic [OUT_BITS-1:0]  result_i
);
  localparam logic [WORK_BITS-1:0] MAG_LIMIT = WORK_BITS'(1) << DIV_BITS;

  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r4_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(busy_i));

  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_i));

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && start_i) |=> busy_i);

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_abs_i < MAG_LIMIT);

  a_r3_result_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&sum_full_i[WORK_BITS-1:OUT_BITS-1]) || !(|sum_full_i[WORK_BITS-1:OUT_BITS-1]));
endmodule

bind tsense_poly_conv tsense_poly_conv_chk #(
  .WORK_BITS (WORK_BITS),
  .OUT_BITS  (OUT_BITS),
  .DIV_BITS  (DIV_BITS)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n_sync),
  .start_i    (start_i),
  .done_i     (done_o),
  .busy_i     (busy),
  .prod_abs_i (prod_abs),
  .sum_full_i (sum_full),
  .result_i   (result_o)
);

// File: tb/test_tsense_poly_conv.sv
`timescale 1ns/1ps
module test_tsense_poly_conv;
  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [9:0] code;
  logic signed [31:0] result;
  logic done;

  int n_chk = 0;
  int n_fail = 0;
  int lat_ref = 0;

  always #5 clk = ~clk;

  tsense_poly_conv i_tsense_poly_conv (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .code_i   (code),
    .result_o (result),
    .done_o   (done)
  );

  function automatic longint ref_temp(input int n);
    longint c[4] = '{-34627, 110230, -191650, 306040};
    longint sum = -56197;
    for (int k = 0; k < 4; k++) begin
      longint t = c[k];
      for (int j = 0; j < 4 - k; j++) t = (t * n) / 1000;
      sum += t;
    end
    return sum;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Called right after start was driven at a falling edge; drops start after one cycle.
  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      start = 1'b0;
    end while (!done && lat < 2000);
  endtask

  task automatic convert(input int c, output longint res, output int lat);
    @(negedge clk);
    start = 1'b1;
    code  = 10'(c);
    wait_done(lat);
    res = result;
    @(negedge clk);
    check(done == 1'b0, "R4 done width", done, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    code  = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(result == 0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 done after release", done, 0);
    check(result == 0, "R1 result after release", result, 0);
  endtask

  task automatic t_zero();
    longint r;
    int lat;
    convert(0, r, lat);
    lat_ref = lat;
    check(r == -56197, "R2 code zero", r, -56197);
    check(lat > 4 && lat < 2000, "R9 latency sane", lat, lat_ref);
  endtask

  task automatic t_sweep();
    int lat;
    @(negedge clk);
    start = 1'b1;
    code  = 10'd0;
    for (int n = 0; n < 1024; n++) begin
      longint exp = ref_temp(n);
      wait_done(lat);
      check(result == exp, "R3 sweep value", result, exp);
      check(lat == lat_ref, "R9 fixed latency (R8 when restarted in done cycle)", lat, lat_ref);
      if (n < 1023) begin
        start = 1'b1;
        code  = 10'(n + 1);
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", done, 0);
  endtask

  task automatic t_ignore();
    int lat;
    int extra = 0;
    longint exp = ref_temp(700);
    @(negedge clk);
    start = 1'b1;
    code  = 10'd700;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    code  = 10'd100;
    wait_done(lat);
    check(result == exp, "R5 late start ignored", result, exp);
    repeat (300) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R5 no extra done", extra, 0);
    check(result == exp, "R5 result kept", result, exp);
  endtask

  task automatic t_code_change();
    int lat;
    longint exp = ref_temp(300);
    @(negedge clk);
    start = 1'b1;
    code  = 10'd300;
    @(negedge clk);
    start = 1'b0;
    code  = 10'd900;
    wait_done(lat);
    check(result == exp, "R6 code captured at start", result, exp);
    check(lat == lat_ref + 0 - 0 || lat == lat_ref - 1, "R9 latency code change", lat, lat_ref);
  endtask

  task automatic t_hold();
    longint r;
    int lat;
    longint held;
    convert(1023, r, lat);
    check(r == ref_temp(1023), "R3 top code", r, ref_temp(1023));
    held = result;
    for (int k = 0; k < 5; k++) begin
      code = 10'(k * 97);
      repeat (30) @(negedge clk);
      check(result == held && done == 1'b0, "R7 result holds", result, held);
    end
  endtask

  initial begin
    #1_900_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_sweep();
    t_ignore();
    t_code_change();
    t_hold();
    summary();
    $finish;
  end
endmodule